// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical sync, blanking and display-enable signals for a raster display. It runs on the character clock: every clock edge is one character clock, one step of the horizontal counter, which stands for four pixels. The vertical counter counts whole lines. Each axis is shaped by four programmable edge values: end of sync, end of blank, start of blank and total.

A host programs the edges over a simple 32-bit register bus with word-aligned byte offsets. It can also read back the running counters at any time. A line-compare register raises a sticky interrupt flag when the line counter reaches a chosen line. New edge values are held in a staging copy and only reach the counters at the next frame boundary, so a frame is never drawn with a mix of old and new timing.

The register offsets are fixed. Horizontal: 0x00 end-sync, 0x04 end-blank, 0x08 start-blank, 0x0C total, 0x10 counter (read-only). Vertical: 0x14 end-sync, 0x18 end-blank, 0x1C start-blank, 0x20 total, 0x24 counter (read-only). 0x28 is the interrupt line. 0x2C is interrupt status and control.

Top module: `crtc_timing_gen`

## Requirements
- R1: While reset is held, both counters read 0 and the status register at 0x2C reads 0. The timing registers read their defaults: horizontal 2, 4, 12, 15 and vertical 1, 2, 8, 9 (end-sync, end-blank, start-blank, total), and the line-compare register reads 0.
- R2: The horizontal counter steps by one each clock from 0 up to the total value inclusive, then returns to 0.
- R3: The vertical counter steps by one on each horizontal return to 0. After reaching the vertical total it returns to 0 instead.
- R4: hsync is high while the horizontal count is below the end-sync value. vsync is high while the line count is below the vertical end-sync value.
- R5: A blank output is high while its count is at or above start-blank or below end-blank. display_en is high only when both blanks are low.
- R6: Written timing and line-compare values read back at once. They steer the counters, syncs, blanks and interrupt only from the clock edge on which both counters return to 0.
- R7: Only bits [15:0] of a write are stored. Reads of timing registers return the stored value with bits [31:16] zero.
- R8: Reads at 0x10 and 0x24 return the live horizontal and line counts. Writes to those offsets change nothing.
- R9: The status flag (bit 0 at 0x2C) is set by the clock edge at which the line count equals the line-compare value and the horizontal count is 0. It stays set until cleared.
- R10: A write to 0x2C with bit 0 set clears the flag. With bit 0 clear, the write leaves the flag unchanged.
- R11: irq equals the flag ANDed with the enable bit. The enable bit is bit 1 of 0x2C and is loaded by every write to that offset.
- R12: When a clearing write and a setting condition meet on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| display_en | output | 1 | Active picture area |
| irq | output | 1 | Line-compare interrupt |

## Verification
The line-compare setting and a host clear of the status flag can fall on the same edge. The bench provokes this by issuing the clearing write so that its capturing edge is the one at which the counters sit at the compare line and column 0. It then judges the status register and irq one cycle later, expecting both set. A second case puts a register write near the frame boundary. Every cycle of the following frames is compared against a counter model that swaps in staged values only at the frame wrap.

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen #(
  parameter int CW = 16,
  parameter logic [CW-1:0] RST_HES  = 2,
  parameter logic [CW-1:0] RST_HEB  = 4,
  parameter logic [CW-1:0] RST_HSB  = 12,
  parameter logic [CW-1:0] RST_HTOT = 15,
  parameter logic [CW-1:0] RST_VES  = 1,
  parameter logic [CW-1:0] RST_VEB  = 2,
  parameter logic [CW-1:0] RST_VSB  = 8,
  parameter logic [CW-1:0] RST_VTOT = 9,
  parameter logic [CW-1:0] RST_VINT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        hsync,
  output logic        vsync,
  output logic        hblank,
  output logic        vblank,
  output logic        display_en,
  output logic        irq
);
  localparam int PADW = 32 - CW;

  logic [CW-1:0] hes_s, heb_s, hsb_s, htot_s, ves_s, veb_s, vsb_s, vtot_s, vint_s;
  logic [CW-1:0] hes_l, heb_l, hsb_l, htot_l, ves_l, veb_l, vsb_l, vtot_l, vint_l;
  logic [CW-1:0] hcnt, vcnt;
  logic          flag, en;

  wire [3:0] widx  = bus_addr[5:2];
  wire       hwrap = (hcnt == htot_l);
  wire       fwrap = hwrap && (vcnt == vtot_l);
  wire       vhit  = (hcnt == '0) && (vcnt == vint_l);
  wire       clr   = bus_wr && (widx == 4'd11) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hes_s <= RST_HES;  heb_s <= RST_HEB;  hsb_s <= RST_HSB;  htot_s <= RST_HTOT;
      ves_s <= RST_VES;  veb_s <= RST_VEB;  vsb_s <= RST_VSB;  vtot_s <= RST_VTOT;
      vint_s <= RST_VINT;
      en <= 1'b0;
    end else if (bus_wr) begin
      case (widx)
        4'd0:  hes_s  <= bus_wdata[CW-1:0];
        4'd1:  heb_s  <= bus_wdata[CW-1:0];
        4'd2:  hsb_s  <= bus_wdata[CW-1:0];
        4'd3:  htot_s <= bus_wdata[CW-1:0];
        4'd5:  ves_s  <= bus_wdata[CW-1:0];
        4'd6:  veb_s  <= bus_wdata[CW-1:0];
        4'd7:  vsb_s  <= bus_wdata[CW-1:0];
        4'd8:  vtot_s <= bus_wdata[CW-1:0];
        4'd10: vint_s <= bus_wdata[CW-1:0];
        4'd11: en     <= bus_wdata[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hes_l <= RST_HES;  heb_l <= RST_HEB;  hsb_l <= RST_HSB;  htot_l <= RST_HTOT;
      ves_l <= RST_VES;  veb_l <= RST_VEB;  vsb_l <= RST_VSB;  vtot_l <= RST_VTOT;
      vint_l <= RST_VINT;
    end else if (fwrap) begin
      hes_l <= hes_s;  heb_l <= heb_s;  hsb_l <= hsb_s;  htot_l <= htot_s;
      ves_l <= ves_s;  veb_l <= veb_s;  vsb_l <= vsb_s;  vtot_l <= vtot_s;
      vint_l <= vint_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hwrap) begin
      hcnt <= '0;
      vcnt <= (vcnt == vtot_l) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (vhit) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  assign hsync      = hcnt < hes_l;
  assign vsync      = vcnt < ves_l;
  assign hblank     = (hcnt >= hsb_l) || (hcnt < heb_l);
  assign vblank     = (vcnt >= vsb_l) || (vcnt < veb_l);
  assign display_en = !hblank && !vblank;
  assign irq        = flag && en;

  always_comb begin
    case (widx)
      4'd0:    bus_rdata = {{PADW{1'b0}}, hes_s};
      4'd1:    bus_rdata = {{PADW{1'b0}}, heb_s};
      4'd2:    bus_rdata = {{PADW{1'b0}}, hsb_s};
      4'd3:    bus_rdata = {{PADW{1'b0}}, htot_s};
      4'd4:    bus_rdata = {{PADW{1'b0}}, hcnt};
      4'd5:    bus_rdata = {{PADW{1'b0}}, ves_s};
      4'd6:    bus_rdata = {{PADW{1'b0}}, veb_s};
      4'd7:    bus_rdata = {{PADW{1'b0}}, vsb_s};
      4'd8:    bus_rdata = {{PADW{1'b0}}, vtot_s};
      4'd9:    bus_rdata = {{PADW{1'b0}}, vcnt};
      4'd10:   bus_rdata = {{PADW{1'b0}}, vint_s};
      4'd11:   bus_rdata = {30'd0, en, flag};
      default: bus_rdata = '0;
    endcase
  end

  a_r2_hcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= htot_l);
  a_r2_hcnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    hwrap |=> (hcnt == '0));
  a_r3_vcnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hwrap && (vcnt != vtot_l)) |=> (vcnt == $past(vcnt) + 1'b1));
  a_r3_vcnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hwrap |=> $stable(vcnt));
  a_r6_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fwrap |=> ($stable(htot_l) && $stable(vtot_l) && $stable(vint_l)));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    vhit |=> flag);
endmodule

// File: tb/crtc_timing_gen_tb.sv
module crtc_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic hsync, vsync, hblank, vblank, display_en, irq;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crtc_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync), .vsync(vsync),
    .hblank(hblank), .vblank(vblank), .display_en(display_en), .irq(irq)
  );

  // staged copy (index = offset/4) and applied copy of the model
  logic [15:0] bs [0:10];
  logic [15:0] ml [0:10];
  logic [15:0] mh, mv;

  function automatic logic [15:0] dflt(int i);
    case (i)
      0: return 2;  1: return 4;  2: return 12; 3: return 15;
      5: return 1;  6: return 2;  7: return 8;  8: return 9;
      default: return 0;
    endcase
  endfunction

  initial for (int i = 0; i < 11; i++) bs[i] = dflt(i);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh <= 0; mv <= 0;
      for (int i = 0; i < 11; i++) ml[i] <= dflt(i);
    end else if (mh == ml[3]) begin
      mh <= 0;
      if (mv == ml[8]) begin
        mv <= 0;
        for (int i = 0; i < 11; i++) ml[i] <= bs[i];
      end else mv <= mv + 1;
    end else mh <= mh + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h (h=%0d v=%0d)", tag, act, exp, mh, mv);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    if (a[5:2] != 4 && a[5:2] != 9 && a[5:2] < 11) bs[a[5:2]] <= d[15:0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_pos(logic [15:0] v, logic [15:0] h);
    do @(negedge clk); while (!(mv == v && mh == h));
  endtask

  task automatic cmp_cycles(int n, string tag);
    logic [31:0] d;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd(6'h10, d); chk({tag, " R2 R8 hcnt"}, d, {16'd0, mh});
      rd(6'h24, d); chk({tag, " R3 R8 vcnt"}, d, {16'd0, mv});
      chk({tag, " R4 hsync"}, hsync, mh < ml[0]);
      chk({tag, " R4 vsync"}, vsync, mv < ml[5]);
      chk({tag, " R5 hblank"}, hblank, (mh >= ml[2]) || (mh < ml[1]));
      chk({tag, " R5 vblank"}, vblank, (mv >= ml[7]) || (mv < ml[6]));
      chk({tag, " R5 display_en"}, display_en,
          !((mh >= ml[2]) || (mh < ml[1])) && !((mv >= ml[7]) || (mv < ml[6])));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(6'h10, d); chk("R1 hcnt", d, 0);
    rd(6'h24, d); chk("R1 vcnt", d, 0);
    rd(6'h2C, d); chk("R1 status", d, 0);
    for (int i = 0; i < 11; i++) begin
      if (i == 4 || i == 9) continue;
      rd(6'(i * 4), d); chk("R1 default", d, {16'd0, dflt(i)});
    end
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_sweep();
    cmp_cycles(2 * 16 * 10 + 5, "sweep");
  endtask

  task automatic t_reprogram();
    logic [31:0] d;
    wait_pos(4, 3);
    wr(6'h0C, 32'hABCD_0013);
    rd(6'h0C, d); chk("R7 upper half dropped", d, 32'h13);
    wr(6'h00, 32'hFFFF_0003);
    rd(6'h00, d); chk("R6 R7 readback", d, 32'h3);
    wr(6'h04, 5);  wr(6'h08, 17);
    wr(6'h14, 2);  wr(6'h18, 3);  wr(6'h1C, 10); wr(6'h20, 11);
    cmp_cycles(3 * 20 * 12, "R6 deferred apply");
  endtask

  task automatic t_counters_ro();
    wait_pos(2, 7);
    wr(6'h10, 32'h5);
    wr(6'h24, 32'h7);
    cmp_cycles(2 * 20 * 12, "R8 write ignored");
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(6'h28, 4);
    wait_pos(ml[8], ml[3]);
    wait_pos(1, 0);
    wr(6'h2C, 32'h3);
    rd(6'h2C, d); chk("R10 clear", d, 32'h2);
    wait_pos(4, 0);
    rd(6'h2C, d); chk("R9 not yet set", d, 32'h2);
    chk("R11 irq low", irq, 0);
    @(negedge clk);
    rd(6'h2C, d); chk("R9 set on line", d, 32'h3);
    chk("R11 irq high", irq, 1);
    wait_pos(6, 2);
    rd(6'h2C, d); chk("R9 sticky", d, 32'h3);
    wr(6'h2C, 32'h2);
    rd(6'h2C, d); chk("R10 bit0 clear keeps flag", d, 32'h3);
    wr(6'h2C, 32'h3);
    rd(6'h2C, d); chk("R10 cleared", d, 32'h2);
    chk("R10 irq low", irq, 0);
    wr(6'h2C, 32'h0);
    wait_pos(4, 1);
    rd(6'h2C, d); chk("R11 flag without enable", d, 32'h1);
    chk("R11 irq gated", irq, 0);
    wr(6'h2C, 32'h2);
    chk("R11 irq enabled", irq, 1);
    wr(6'h2C, 32'h3);
    rd(6'h2C, d); chk("R12 pre-clear", d, 32'h2);
    wait_pos(4, 0);
    wr(6'h2C, 32'h3);
    rd(6'h2C, d); chk("R12 set wins", d, 32'h3);
    chk("R12 irq", irq, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_sweep();
    t_reprogram();
    t_counters_ro();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule